// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a virtual address into a physical address by walking a four-level radix page table held in memory. A request carries a 64-bit virtual address. Of its bits, only the low 48 are used: the upper 16 are discarded, the low 12 form the byte offset within a 4 KB page, and the 36 bits between them split into four 9-bit index fields. The walk starts from a root table whose frame number sits in a base register that is loaded only while the block is idle.

For each level, the walker issues one 64-bit read on a valid/ready memory request channel. It then waits for the matching response, which arrives on a response channel that has only a valid signal. Each entry carries a present flag in bit 0 and the frame of the next table, or of the final page, in bits 51:12.

A walk ends with a one-cycle done pulse and the physical address. The physical address is the final frame followed by the untouched page offset. If any entry on the way is not present, the walk instead ends with a one-cycle fault pulse and the number of the level that failed.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req_valid`, `done` and `fault` are 0.
- R2: Bits 63:48 of `req_vaddr` have no effect on any memory read address or on the result.
- R3: Bits 11:0 of `paddr` equal bits 11:0 of the accepted virtual address.
- R4: The walk reads levels 0 to 3 in order. Level k uses the index field at virtual-address bits (47-9k):(39-9k), so level 0 uses 47:39 and level 3 uses 20:12. Its read address is the table frame times 4096 plus the index times 8, and the level 0 table frame is the root register.
- R5: For levels 1 to 3, the table frame is bits 51:12 of the entry that the previous level returned.
- R6: When an entry returned at level k has bit 0 equal to 0, the block pulses `fault` for one cycle with `fault_level` = k (0 is the topmost level), and issues no further read for that request.
- R7: When all four entries are present, the block pulses `done` for one cycle one clock after the level 3 response. At that point `paddr` = {level 3 entry bits 51:12, offset}.
- R8: A root write (`root_we`) takes effect only while `req_ready` is 1. A write during a walk is ignored. A request captures the root value held before its acceptance cycle.
- R9: A request is accepted only when `req_ready` is 1. Every accepted request gets exactly one `done` or `fault` pulse, never both. `req_valid` is ignored while a walk is in progress.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid with an unchanged address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_we | input | 1 | Load the root frame register (idle only) |
| root_frame | input | 40 | Root table frame number |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 64 | Virtual address to translate |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle pulse: translation complete |
| fault | output | 1 | One-cycle pulse: entry not present |
| fault_level | output | 2 | Level whose entry was not present |
| paddr | output | 52 | Translated physical address |

## Verification
Some properties are checked by assertions on every cycle. They cover the hold of an unaccepted memory read and 8-byte alignment of every read address. They also check that a walk never ends in both `done` and `fault`, that a result only appears when the walker is back to idle with no read outstanding, and that the page offset of the result matches the accepted address. The remaining behaviour can only be shown by the bench's scenarios, which run against a memory model with random latency and random back-pressure. These scenarios cover the exact order and addresses of the four reads, the chaining of frames through the levels, and fault reporting at each level. They also show that the top address bits and root writes issued during a walk have no effect.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4,
  parameter int ENT_W  = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         root_we,
  input  logic [PA_W-OFF_W-1:0]        root_frame,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [63:0]                  req_vaddr,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic [PA_W-1:0]              mem_req_addr,
  input  logic                         mem_rsp_valid,
  input  logic [ENT_W-1:0]             mem_rsp_data,
  output logic                         done,
  output logic                         fault,
  output logic [$clog2(LEVELS)-1:0]    fault_level,
  output logic [PA_W-1:0]              paddr
);
  localparam int FRM_W  = PA_W - OFF_W;
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int ENT_SH = $clog2(ENT_W / 8);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;

  state_t             st;
  logic [FRM_W-1:0]   root, base;
  logic [VA_W-1:0]    va;
  logic [LVL_W-1:0]   lvl;
  logic [IDX_W-1:0]   idx;
  logic [FRM_W-1:0]   nxt_frame;
  logic               last_lvl;

  assign idx       = va[OFF_W + IDX_W*(LEVELS-1-int'(lvl)) +: IDX_W];
  assign nxt_frame = mem_rsp_data[PA_W-1:OFF_W];
  assign last_lvl  = (lvl == LVL_W'(LEVELS-1));

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = {base, OFF_W'({idx, {ENT_SH{1'b0}}})};

  wire unused_bits = ^{req_vaddr[63:VA_W], mem_rsp_data[ENT_W-1:PA_W], mem_rsp_data[OFF_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      root        <= '0;
      base        <= '0;
      va          <= '0;
      lvl         <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_level <= '0;
      paddr       <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: begin
          if (root_we) root <= root_frame;
          if (req_valid) begin
            va   <= req_vaddr[VA_W-1:0];
            base <= root;
            lvl  <= '0;
            st   <= S_REQ;
          end
        end
        S_REQ: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: begin
          if (mem_rsp_valid) begin
            if (!mem_rsp_data[0]) begin
              fault       <= 1'b1;
              fault_level <= lvl;
              st          <= S_IDLE;
            end else if (last_lvl) begin
              done  <= 1'b1;
              paddr <= {nxt_frame, va[OFF_W-1:0]};
              st    <= S_IDLE;
            end else begin
              base <= nxt_frame;
              lvl  <= lvl + 1'b1;
              st   <= S_REQ;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W  = 52,
  parameter int OFF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OFF_W-1:0] va_off,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             done,
  input logic             fault,
  input logic [PA_W-1:0]  paddr
);
  logic [OFF_W-1:0] off_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) off_q <= '0;
    else if (req_valid && req_ready) off_q <= va_off;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
  AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000); // R4
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault)); // R9
  AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> req_ready && !mem_req_valid); // R9
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid); // R6
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> paddr[OFF_W-1:0] == off_q); // R3
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .va_off(req_vaddr[OFF_W-1:0]), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .done(done), .fault(fault), .paddr(paddr)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        root_we = 1'b0, req_valid = 1'b0;
  logic [39:0] root_frame = '0;
  logic [63:0] req_vaddr = '0;
  logic        req_ready, mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [51:0] mem_req_addr, paddr;
  logic [63:0] mem_rsp_data;
  logic        done, fault;
  logic [1:0]  fault_level;

  pt_walker dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  int rd_cnt = 0, got_n = 0, force_g = -1;
  logic [51:0] got_addr [8];
  logic [39:0] cur_root = '0;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [63:0] entry(input logic [51:0] a, input int l, input int frc);
    logic [63:0] x;
    x = {12'h0, a} * 64'h9E3779B97F4A7C15;
    x = x ^ (x >> 29);
    if (l == frc) x[0] = 1'b0;
    else if (frc == -2) x[0] = 1'b1;
    else x[0] = (x[7:4] != 4'h0);
    return x;
  endfunction

  // memory model: random ready, 1..3 cycle response latency
  initial begin
    int cnt = 0;
    bit hold = 0;
    logic [51:0] hold_a = '0;
    logic [63:0] pend = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = pend; end
      end
      if (hold) begin
        chk("R10 hold", {11'h0, mem_req_valid, mem_req_addr}, {11'h0, 1'b1, hold_a});
        hold = 0;
      end
      mem_req_ready = ($urandom % 3) != 0;
      if (mem_req_valid && mem_req_ready) begin
        if (got_n < 8) got_addr[got_n] = mem_req_addr;
        got_n++;
        pend = entry(mem_req_addr, rd_cnt, force_g);
        rd_cnt++;
        cnt = 1 + int'($urandom % 3);
      end else if (mem_req_valid) begin
        hold = 1; hold_a = mem_req_addr;
      end
    end
  end

  task automatic load_root(input logic [39:0] v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    root_we = 1'b1; root_frame = v;
    @(negedge clk);
    root_we = 1'b0;
    cur_root = v;
  endtask

  task automatic run_walk(input logic [63:0] va, input int frc, input bit poke,
                          output logic [51:0] res);
    logic [39:0] b;
    logic [51:0] ea [4];
    logic [63:0] e;
    int nrd, flv;
    bit seen_d, seen_f;
    int pulses;
    b = cur_root; nrd = 4; flv = -1;
    for (int l = 0; l < 4; l++) begin
      ea[l] = {b, va[47-9*l -: 9], 3'b000};
      e = entry(ea[l], l, frc);
      if (!e[0]) begin flv = l; nrd = l + 1; break; end
      b = e[51:12];
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    force_g = frc; rd_cnt = 0; got_n = 0;
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_vaddr = ~va;             // R9: held request while busy must be ignored
    seen_d = 0; seen_f = 0; pulses = 0;
    for (int c = 0; c < 100; c++) begin
      root_we = poke && (c == 0);  // R8: write while busy
      root_frame = ~cur_root;
      if (done || fault) begin
        seen_d = done; seen_f = fault; pulses++;
        res = paddr;
        chk("R6 fault_level", {62'h0, fault_level}, flv < 0 ? {62'h0, fault_level} : 64'(flv));
        req_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
    root_we = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    if (done || fault) pulses++;
    chk("R9 one response", 64'(pulses), 64'd1);
    chk("R4/R6 read count", 64'(got_n), 64'(nrd));
    for (int l = 0; l < nrd && l < got_n; l++)
      chk(l == 0 ? "R4 root read addr" : "R5 chained read addr", {12'h0, got_addr[l]}, {12'h0, ea[l]});
    if (flv < 0) begin
      chk("R7 done", {62'h0, seen_d, seen_f}, 64'd2);
      chk("R7 paddr", {12'h0, res}, {12'h0, b, va[11:0]});
      chk("R3 offset", {52'h0, res[11:0]}, {52'h0, va[11:0]});
    end else
      chk("R6 fault", {62'h0, seen_d, seen_f}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [51:0] r1, r2;
    logic [63:0] va;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset", {60'h0, req_ready, mem_req_valid, done, fault}, 64'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {60'h0, req_ready, mem_req_valid, done, fault}, 64'b1000);

    load_root(40'h12345_6789A);                       // R8 idle load
    run_walk(64'h0000_7FFF_FFFF_F123, -2, 0, r1);
    run_walk(64'h0000_0000_0000_0000, -2, 0, r1);
    va = 64'h0000_5A5A_C3C3_1ABC;
    run_walk(va, -2, 0, r1);
    run_walk({16'hBEEF, va[47:0]}, -2, 0, r2);        // R2
    chk("R2 top bits ignored", {12'h0, r2}, {12'h0, r1});
    for (int l = 0; l < 4; l++)                       // R6 each level
      run_walk(64'h0000_1234_5678_9FFF ^ (64'(l) << 20), l, 0, r1);
    run_walk(64'h0000_0F0F_0F0F_0F0F, -2, 1, r1);     // R8 busy write ignored
    run_walk(64'h0000_0F0F_0F0F_0F0F, -2, 0, r2);
    chk("R8 busy write ignored", {12'h0, r2}, {12'h0, r1});

    for (int i = 0; i < 60; i++) begin
      if ($urandom % 4 == 0) load_root({$urandom, $urandom} & 40'hFF_FFFF_FFFF);
      va = {$urandom, $urandom};
      run_walk(va, -1, ($urandom % 5) == 0, r1);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule